// File: doc/BRIEF.md
# Slot Interrupt Swizzle and Steering Router

This block collects the active-low interrupt pins of seven expansion slots, four pins per slot, and folds them onto four shared link lines. The pins reach the links through a rotation that advances by one link per slot. Cards that use only their first pin are therefore spread evenly over all four links rather than piling onto one.

Each link then passes through a small steering table that software writes through a one-word write port. The table either sends the link to one of sixteen legacy interrupt request lines or disables it. A reserved mask protects request lines that are kept for legacy devices: a write that would steer a link onto a protected line is refused and flagged.

The outputs are a registered 16-bit active-high request vector, a per-link level view, and a read port that returns one link's level and steering code. Sharing is level based throughout. A request line stays high for as long as any contributing pin is held low, with nothing latched.

Top module: `irq_steer_router`

## Requirements
- R1: After reset every link's steering code reads 5'h10 (disabled), `irq_req` is all zero and `wr_err` is low.
- R2: Bit `(s*4)+p` of `slot_int_n` is pin p (A=0, B=1, C=2, D=3) of zero-based slot s, and it feeds link `(p - s) mod 4` (link A=0 … D=3).
- R3: A link's bit in `link_level` is high exactly when at least one pin wired to it is low. The change appears two clock edges after the pin change, through a two-stage synchroniser.
- R4: `irq_req[k]` is high one edge after a link level that is enabled and steered to k goes high, and it drops one edge after that level drops. It is never latched.
- R5: A steering code with bit 4 set disables its link. A disabled link drives no request line, whatever its lower four bits hold.
- R6: A write of a code below 16 whose bit in `reserved_mask` is set is refused. The stored code keeps its previous value and `wr_err` is high for the single cycle after that write edge.
- R7: When several enabled links are steered to the same request line, that line is the OR of their levels.
- R8: `rd_level` and `rd_code` show, without delay, the level and stored code of the link selected by `rd_link`.
- R9: An accepted write changes the stored code at its write edge. The request vector follows the new code from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_int_n | input | 28 | Slot interrupt pins, active low, bit = slot*4 + pin |
| wr_en | input | 1 | Steering write strobe |
| wr_link | input | 2 | Link whose steering code is written |
| wr_code | input | 5 | New steering code (bit 4 = disable, bits 3:0 = request line) |
| reserved_mask | input | 16 | Request lines that no write may target |
| rd_link | input | 2 | Link selected for the read port |
| link_level | output | 4 | Synchronised level of each link, active high |
| rd_level | output | 1 | Level of the selected link |
| rd_code | output | 5 | Stored steering code of the selected link |
| irq_req | output | 16 | Registered legacy request vector, active high |
| wr_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The assertions assume that `wr_en`, `wr_link`, `wr_code` and `reserved_mask` hold known values around each clock edge. They also assume the slot pins are never X once reset ends. This matters because the refusal check and the steering decode index with those values. The bench drives every input one nanosecond after the falling edge, so all inputs are settled and defined at each rising edge. Write strobes last exactly one cycle. The reserved mask changes only between writes in the random phase, and the behavioural model also samples it at the rising edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Pin of a slot that lands on a given link under the per-slot rotation.
    function automatic int pin_for_link(input int link, input int slot, input int npins);
        return (link + slot) % npins;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W      = 28,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_n,
    output logic [W-1:0] dout_n
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din_n;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_n = st_q.stg[STAGES-1];

endmodule

// File: rtl/irq_link_swizzle.sv
module irq_link_swizzle
    import irq_router_pkg::*;
#(
    parameter int N_SLOTS = 7,
    parameter int N_PINS  = 4
) (
    input  logic [N_SLOTS*N_PINS-1:0] pins_n,
    output logic [N_PINS-1:0]         link_lvl
);
    logic [N_PINS-1:0][N_SLOTS-1:0] hit;

    for (genvar l = 0; l < N_PINS; l++) begin : g_link
        for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
            localparam int PIX = s * N_PINS + pin_for_link(l, s, N_PINS);
            assign hit[l][s] = ~pins_n[PIX];
        end
        assign link_lvl[l] = |hit[l];
    end

endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs #(
    parameter int N_LINKS = 4,
    parameter int N_IRQ   = 16,
    localparam int LW     = $clog2(N_LINKS),
    localparam int IW     = $clog2(N_IRQ),
    localparam int CW     = IW + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [LW-1:0]              wr_link,
    input  logic [CW-1:0]              wr_code,
    input  logic [N_IRQ-1:0]           reserved_mask,
    output logic [N_LINKS-1:0][CW-1:0] map,
    output logic                       wr_err
);
    typedef struct packed {
        logic [N_LINKS-1:0][CW-1:0] map;
        logic                       err;
    } map_st_t;

    map_st_t st_d, st_q;
    logic    refuse;

    assign refuse = wr_en && !wr_code[CW-1] && reserved_mask[wr_code[IW-1:0]];

    always_comb begin
        st_d     = st_q;
        st_d.err = refuse;
        if (wr_en && !refuse) begin
            st_d.map[wr_link] = wr_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < N_LINKS; l++) begin
                st_q.map[l] <= CW'(1) << IW;
            end
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map    = st_q.map;
    assign wr_err = st_q.err;

    // A refused write leaves every stored code untouched and raises the flag.
    assert_refuse_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_code[CW-1] && reserved_mask[wr_code[IW-1:0]])
        |=> (wr_err && $stable(st_q.map)));

    // The flag only follows a write strobe.
    assert_err_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    // An accepted write lands in the addressed register at its edge.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(!wr_code[CW-1] && reserved_mask[wr_code[IW-1:0]]))
        |=> (st_q.map[$past(wr_link)] == $past(wr_code)));

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_router_pkg::*;
#(
    parameter int N_SLOTS     = 7,
    parameter int N_PINS      = 4,
    parameter int N_IRQ       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int N_LINKS    = N_PINS,
    localparam int N_IN       = N_SLOTS * N_PINS,
    localparam int LW         = $clog2(N_LINKS),
    localparam int IW         = $clog2(N_IRQ),
    localparam int CW         = IW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IN-1:0]    slot_int_n,
    input  logic               wr_en,
    input  logic [LW-1:0]      wr_link,
    input  logic [CW-1:0]      wr_code,
    input  logic [N_IRQ-1:0]   reserved_mask,
    input  logic [LW-1:0]      rd_link,
    output logic [N_LINKS-1:0] link_level,
    output logic               rd_level,
    output logic [CW-1:0]      rd_code,
    output logic [N_IRQ-1:0]   irq_req,
    output logic               wr_err
);
    typedef struct packed {
        logic [N_IRQ-1:0] irq;
    } out_st_t;

    logic [N_IN-1:0]            pins_sync_n;
    logic [N_LINKS-1:0]         link_lvl;
    logic [N_LINKS-1:0][CW-1:0] map;
    logic                       all_dis;
    out_st_t                    st_d, st_q;

    irq_pin_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (slot_int_n),
        .dout_n (pins_sync_n)
    );

    irq_link_swizzle #(.N_SLOTS(N_SLOTS), .N_PINS(N_PINS)) u_swz (
        .pins_n   (pins_sync_n),
        .link_lvl (link_lvl)
    );

    irq_map_regs #(.N_LINKS(N_LINKS), .N_IRQ(N_IRQ)) u_map (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_link       (wr_link),
        .wr_code       (wr_code),
        .reserved_mask (reserved_mask),
        .map           (map),
        .wr_err        (wr_err)
    );

    always_comb begin
        st_d = '0;
        for (int k = 0; k < N_IRQ; k++) begin
            for (int l = 0; l < N_LINKS; l++) begin
                if (link_lvl[l] && !map[l][CW-1] && (map[l][IW-1:0] == IW'(k))) begin
                    st_d.irq[k] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        all_dis = 1'b1;
        for (int l = 0; l < N_LINKS; l++) begin
            all_dis = all_dis & map[l][CW-1];
        end
    end

    assign irq_req    = st_q.irq;
    assign link_level = link_lvl;
    assign rd_level   = link_lvl[rd_link];
    assign rd_code    = map[rd_link];

    // With every synchronised pin idle, no link may be active.
    assert_idle_links_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&pins_sync_n) |-> (link_lvl == '0));

    // A request line can only be high if some link was active an edge before.
    assert_irq_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> $past(|link_lvl));

    // With every link disabled, the next request vector is empty.
    assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(all_dis) |-> (irq_req == '0));

endmodule

// File: tb/sim_irq_steer_router.sv
`timescale 1ns/1ps
module sim_irq_steer_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] slot_int_n = '1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_link = '0;
    logic [4:0]  wr_code = '0;
    logic [15:0] reserved_mask = 16'h4008;
    logic [1:0]  rd_link = '0;
    logic [3:0]  link_level;
    logic        rd_level;
    logic [4:0]  rd_code;
    logic [15:0] irq_req;
    logic        wr_err;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    irq_steer_router u0 (
        .clk(clk), .rst_n(rst_n), .slot_int_n(slot_int_n), .wr_en(wr_en),
        .wr_link(wr_link), .wr_code(wr_code), .reserved_mask(reserved_mask),
        .rd_link(rd_link), .link_level(link_level), .rd_level(rd_level),
        .rd_code(rd_code), .irq_req(irq_req), .wr_err(wr_err)
    );

    // Behavioural reference model
    logic [27:0] m_s1, m_s2;
    int          m_map [4];
    logic [15:0] m_irq;
    logic        m_err;

    function automatic int link_of(input int s, input int p);
        return (((p - s) % 4) + 4) % 4;
    endfunction

    function automatic logic [3:0] model_links(input logic [27:0] v);
        logic [3:0] r = '0;
        for (int s = 0; s < 7; s++)
            for (int p = 0; p < 4; p++)
                if (!v[s*4+p]) r[link_of(s, p)] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        logic [3:0]  lv;
        logic [15:0] nirq;
        bit          bad;
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_irq <= '0; m_err <= 1'b0;
            for (int l = 0; l < 4; l++) m_map[l] = 16;
        end else begin
            lv   = model_links(m_s2);
            nirq = '0;
            for (int l = 0; l < 4; l++)
                if (lv[l] && m_map[l] < 16) nirq[m_map[l]] = 1'b1;
            bad = wr_en && (int'(wr_code) < 16) && reserved_mask[wr_code[3:0]];
            m_irq <= nirq;
            m_err <= bad;
            if (wr_en && !bad) m_map[wr_link] = int'(wr_code);
            m_s2 <= m_s1;
            m_s1 <= slot_int_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R4 irq_req vs model", 32'(irq_req), 32'(m_irq));
            chk("R3 link_level vs model", 32'(link_level), 32'(model_links(m_s2)));
            chk("R6 wr_err vs model", 32'(wr_err), 32'(m_err));
            chk("R8 rd_code vs model", 32'(rd_code), 32'(m_map[rd_link]));
            chk("R8 rd_level vs model", 32'(rd_level), 32'(model_links(m_s2)[rd_link]));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic write_map(input int link, input int code);
        wr_en = 1'b1; wr_link = 2'(link); wr_code = 5'(code);
        step(1);
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        step(4);
        rst_n = 1'b1;
        live  = 1'b1;
        step(0);
        // R1: reset state
        chk("R1 irq_req after reset", 32'(irq_req), 0);
        chk("R1 wr_err after reset", 32'(wr_err), 0);
        for (int l = 0; l < 4; l++) begin
            rd_link = 2'(l); #0.1;
            chk("R1 code disabled after reset", 32'(rd_code), 32'h10);
        end

        // R2: every single pin lands on its rotated link
        for (int s = 0; s < 7; s++) begin
            for (int p = 0; p < 4; p++) begin
                slot_int_n = '1; slot_int_n[s*4+p] = 1'b0;
                step(1);
                chk("R3 level not yet after one edge", 32'(link_level), 0);
                step(1);
                chk("R2 swizzle target", 32'(link_level), 32'(4'b1 << (((p - s) % 4 + 4) % 4)));
                slot_int_n = '1;
                step(2);
            end
        end

        // R3: link A shared by 1A,2B,3C,4D,5A,6B,7C (zero-based slot s, pin s mod 4)
        for (int s = 0; s < 7; s++) slot_int_n[s*4 + (s % 4)] = 1'b0;
        step(2);
        chk("R3 shared pins all on link A", 32'(link_level), 32'h1);
        for (int s = 0; s < 6; s++) begin
            slot_int_n[s*4 + (s % 4)] = 1'b1;
            step(2);
            chk("R3 wired-OR holds while one pin low", 32'(link_level), 32'h1);
        end
        slot_int_n = '1;
        step(2);
        chk("R3 link drops with last pin", 32'(link_level), 0);

        // R6: refused write to reserved line 3
        write_map(1, 9);
        write_map(1, 3);
        step(0);
        rd_link = 2'd1; #0.1;
        chk("R6 refused write keeps code", 32'(rd_code), 9);
        step(1);
        chk("R6 flag is a single pulse", 32'(wr_err), 0);

        // R5: disable code whose low bits name a reserved line is accepted
        write_map(3, 5'h13);
        rd_link = 2'd3; #0.1;
        chk("R5 disable code stored", 32'(rd_code), 32'h13);
        chk("R6 no flag for disable code", 32'(wr_err), 0);
        slot_int_n[3] = 1'b0;            // slot 0 pin D -> link 3
        step(3);
        chk("R5 disabled link drives nothing", 32'(irq_req), 0);
        slot_int_n = '1;

        // R7: links 0 and 2 both to line 5
        write_map(0, 5);
        write_map(2, 5);
        slot_int_n[0] = 1'b0;            // slot 0 pin A -> link 0
        slot_int_n[2*4+0] = 1'b0;        // slot 2 pin A -> link 2
        step(3);
        chk("R7 merged line", 32'(irq_req), 32'h20);
        slot_int_n[0] = 1'b1;
        step(3);
        chk("R7 line held by other link", 32'(irq_req), 32'h20);
        slot_int_n = '1;
        step(2);
        chk("R4 line still high one edge after link drops", 32'(irq_req), 32'h20);
        step(1);
        chk("R4 no latching", 32'(irq_req), 0);

        // R9: remap while active
        slot_int_n[0] = 1'b0;
        step(4);
        write_map(0, 7);
        rd_link = 2'd0; #0.1;
        chk("R9 code updated at write edge", 32'(rd_code), 7);
        chk("R9 request still old mapping", 32'(irq_req), 32'h20);
        step(1);
        chk("R9 request follows new mapping", 32'(irq_req), 32'h80);
        slot_int_n = '1;
        step(4);

        // Random phase, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            slot_int_n = ~(28'($urandom) & 28'($urandom) & 28'($urandom));
            rd_link = 2'($urandom);
            if (($urandom % 200) == 0) reserved_mask = 16'($urandom) & 16'($urandom);
            if (($urandom % 6) == 0) begin
                wr_en = 1'b1; wr_link = 2'($urandom); wr_code = 5'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            step(1);
        end
        wr_en = 1'b0;
        step(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule